// File: doc/BRIEF.md
# External Bus Idle-Cycle Inserter

This block sits between a CPU-side request queue and the sequencer that runs external memory bus cycles. Each request carries a direction (read or write), a 3-bit area number and a flag that says whether the access goes off-chip at all. The block keeps a record of the most recent external access. Before it lets a new external access start, it checks that record against two rules in a software-writable 8-bit control register. If an enabled rule matches, it holds the request back for exactly one idle bus state.

The first rule covers a read that follows a read to a different area. The second covers a write that follows a read. Each rule has its own enable bit. The other control bits are stored and read back. Bit 5 is also driven out as the area-0 burst-ROM select for the sequencer.

There are two resets. The power-on reset (also used for hardware standby) loads 0xD0 into the register. The manual reset (also used for software standby) keeps the register and only forgets the access record.

Requests flow on a valid/ready handshake. Back-pressure rules:
- The upstream side holds `req_valid` and the request fields steady until `req_ready` is seen high.
- While an idle state is being inserted, `dn_valid` and `req_ready` are both low.
- After the idle state, the request passes through unchanged. It waits on `dn_ready` without any further idle state.

Top module: `bus_idle_gap`

## Requirements
- R1: A power-on reset (`por_n` low for at least one clock) loads the control register with 0xD0: bits 7 and 6 set, bit 5 clear, bits 2..0 zero.
- R2: A manual reset (`man_n` low) leaves the control register unchanged and clears the access record. No request is accepted or forwarded while either reset is low.
- R3: A write (`cfg_we` high with `cfg_wdata`) replaces all 8 bits. `cfg_rdata` shows the new value from the next cycle. Bits 4..0 have no effect on idle insertion.
- R4: When bit 7 is 1, an external read whose area differs from the preceding external access, and that preceding access was a read, gets exactly one idle state (`gap_stall` high for one cycle). When bit 7 is 0, it gets none.
- R5: When bit 6 is 1, an external write whose preceding external access was a read gets exactly one idle state. When bit 6 is 0, it gets none. If both rules apply, only one idle state is inserted.
- R6: A read following a read to the same area never gets an idle state. Any access following an external write never gets an idle state.
- R7: A request with `req_ext` low is never stalled and does not change the access record.
- R8: The first external access after either reset is never stalled.
- R9: `area0_burst` always equals control bit 5.
- R10: When no idle state is inserted, `dn_valid` follows `req_valid`, `req_ready` follows `dn_ready`, and the request fields pass through. During an idle state both `dn_valid` and `req_ready` are low. A request waiting on `dn_ready` after its idle state is not stalled again.
- R11: A register write made in cycle t governs the decision for any request presented from cycle t+1 onward. A request presented in cycle t itself still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / hardware-standby reset, active low, synchronous |
| man_n | input | 1 | Manual / software-standby reset, active low, synchronous |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| area0_burst | output | 1 | Area-0 burst-ROM select (bit 5) |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | AREA_W | Target area number |
| req_ext | input | 1 | 1 = external bus access, 0 = internal-only |
| dn_valid | output | 1 | Request offered to the bus sequencer |
| dn_ready | input | 1 | Sequencer takes the request |
| dn_write | output | 1 | Forwarded direction |
| dn_area | output | AREA_W | Forwarded area |
| dn_ext | output | 1 | Forwarded external flag |
| gap_stall | output | 1 | High in the cycle an idle state is inserted |

## Verification
The bench targets several corner cases, each tied to a specific failure:
- **Read to read, same area versus different area.** Comparing the wrong fields would stall same-area reads or miss area changes.
- **Write followed by read.** A design that ignored the previous direction would stall here.
- **Internal access between two external reads.** A design that updated the record on internal cycles would lose the needed idle state.
- **Request that waits on `dn_ready` after its idle state.** Without a "gap already taken" flag, the design would stall it again on every cycle.
- **Manual reset.** A design that reloaded the register on manual reset would lose written enables.
- **Register write in the same cycle as a request.** This exposes a decision path that bypasses the stored register.

Random traffic then mixes all of these with back-pressure and reconfiguration.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;
  localparam int CFG_W      = 8;
  localparam int AREA_W_DEF = 3;
  localparam logic [CFG_W-1:0] CFG_POR_VAL = 8'hD0;
  // Bit positions decoded by the decision logic and the sequencer.
  localparam int BIT_RD_RD  = 7;
  localparam int BIT_RD_WR  = 6;
  localparam int BIT_BURST0 = 5;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/bus_idle_cfg.sv
module bus_idle_cfg
  import bus_idle_pkg::*;
#(
  parameter int W = CFG_W,
  parameter logic [W-1:0] RESET_VAL = CFG_POR_VAL
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  // Only the power-on reset touches this register; the manual reset is
  // deliberately not an input here.
  always_ff @(posedge clk) begin
    if (!por_n)   q <= RESET_VAL;
    else if (we)  q <= wdata;
  end
endmodule

// File: rtl/bus_idle_track.sv
module bus_idle_track
  import bus_idle_pkg::*;
#(
  parameter int AREA_W = AREA_W_DEF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              man_n,
  input  logic              upd,
  input  acc_kind_e         upd_kind,
  input  logic [AREA_W-1:0] upd_area,
  output logic              last_vld,
  output acc_kind_e         last_kind,
  output logic [AREA_W-1:0] last_area
);
  always_ff @(posedge clk) begin
    if (!por_n || !man_n) begin
      last_vld  <= 1'b0;
      last_kind <= ACC_WRITE;
      last_area <= '0;
    end else if (upd) begin
      last_vld  <= 1'b1;
      last_kind <= upd_kind;
      last_area <= upd_area;
    end
  end
endmodule

// File: rtl/bus_idle_rule.sv
module bus_idle_rule
  import bus_idle_pkg::*;
#(
  parameter int AREA_W = AREA_W_DEF
) (
  input  logic              en_rd_rd,
  input  logic              en_rd_wr,
  input  logic              last_vld,
  input  acc_kind_e         last_kind,
  input  logic [AREA_W-1:0] last_area,
  input  logic              cur_ext,
  input  acc_kind_e         cur_kind,
  input  logic [AREA_W-1:0] cur_area,
  output logic              need_gap
);
  logic prev_read;
  logic hit_rr;
  logic hit_rw;

  always_comb begin
    prev_read = last_vld && (last_kind == ACC_READ);
    hit_rr    = en_rd_rd && (cur_kind == ACC_READ) && (cur_area != last_area);
    hit_rw    = en_rd_wr && (cur_kind == ACC_WRITE);
    need_gap  = cur_ext && prev_read && (hit_rr || hit_rw);
  end
endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bus_idle_pkg::*;
#(
  parameter int AREA_W = AREA_W_DEF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              man_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              area0_burst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_ext,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_write,
  output logic [AREA_W-1:0] dn_area,
  output logic              dn_ext,
  output logic              gap_stall
);
  logic [CFG_W-1:0]  cfg_q;
  logic              last_vld;
  acc_kind_e         last_kind;
  logic [AREA_W-1:0] last_area;
  acc_kind_e         cur_kind;
  logic              need_gap;
  logic              gap_taken;
  logic              running;
  logic              xfer;

  bus_idle_cfg #(.W(CFG_W), .RESET_VAL(CFG_POR_VAL)) u_cfg (
    .clk   (clk),
    .por_n (por_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  assign cur_kind = req_write ? ACC_WRITE : ACC_READ;

  bus_idle_track #(.AREA_W(AREA_W)) u_track (
    .clk       (clk),
    .por_n     (por_n),
    .man_n     (man_n),
    .upd       (xfer && req_ext),
    .upd_kind  (cur_kind),
    .upd_area  (req_area),
    .last_vld  (last_vld),
    .last_kind (last_kind),
    .last_area (last_area)
  );

  bus_idle_rule #(.AREA_W(AREA_W)) u_rule (
    .en_rd_rd  (cfg_q[BIT_RD_RD]),
    .en_rd_wr  (cfg_q[BIT_RD_WR]),
    .last_vld  (last_vld),
    .last_kind (last_kind),
    .last_area (last_area),
    .cur_ext   (req_ext),
    .cur_kind  (cur_kind),
    .cur_area  (req_area),
    .need_gap  (need_gap)
  );

  always_comb begin
    running   = por_n && man_n;
    gap_stall = running && req_valid && need_gap && !gap_taken;
    dn_valid  = running && req_valid && !gap_stall;
    req_ready = running && dn_ready && !gap_stall;
    xfer      = dn_valid && dn_ready;
  end

  // Marks that the pending request already had its idle state.
  always_ff @(posedge clk) begin
    if (!por_n || !man_n) gap_taken <= 1'b0;
    else if (xfer)        gap_taken <= 1'b0;
    else if (gap_stall)   gap_taken <= 1'b1;
  end

  assign dn_write    = req_write;
  assign dn_area     = req_area;
  assign dn_ext      = req_ext;
  assign cfg_rdata   = cfg_q;
  assign area0_burst = cfg_q[BIT_BURST0];
endmodule

// File: rtl/bus_idle_gap_chk.sv
module bus_idle_gap_chk #(
  parameter int AREA_W = 3
) (
  input logic              clk,
  input logic              por_n,
  input logic              man_n,
  input logic              cfg_we,
  input logic [7:0]        cfg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              req_ext,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              gap_stall
);
  logic seen_ext;
  logic seen_read;

  // Shadow of the last external access, rebuilt from the ports.
  always_ff @(posedge clk) begin
    if (!por_n || !man_n) begin
      seen_ext  <= 1'b0;
      seen_read <= 1'b0;
    end else if (dn_valid && dn_ready && req_ext) begin
      seen_ext  <= 1'b1;
      seen_read <= !req_write;
    end
  end

  a_r1_por_value: assert property (@(posedge clk) disable iff (!por_n)
    $rose(por_n) |-> cfg_rdata == 8'hD0);

  a_r2_manual_keeps: assert property (@(posedge clk) disable iff (!por_n)
    (!man_n && !cfg_we) |=> $stable(cfg_rdata));

  a_r4_single_gap: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    gap_stall |=> !gap_stall);

  a_r6_needs_prior_read: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    gap_stall |-> (seen_ext && seen_read));

  a_r7_internal_free: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    gap_stall |-> req_ext);

  a_r8_first_free: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    !seen_ext |-> !gap_stall);

  a_r10_gap_blocks: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    gap_stall |-> (!dn_valid && !req_ready));

  a_r10_valid_source: assert property (@(posedge clk) disable iff (!por_n || !man_n)
    dn_valid |-> req_valid);
endmodule

bind bus_idle_gap bus_idle_gap_chk #(.AREA_W(AREA_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .man_n     (man_n),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_ext   (req_ext),
  .dn_valid  (dn_valid),
  .dn_ready  (dn_ready),
  .gap_stall (gap_stall)
);

// File: tb/tb_bus_idle_gap.sv
module tb_bus_idle_gap;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          por_n, man_n, cfg_we;
  logic [7:0]    cfg_wdata, cfg_rdata;
  logic          area0_burst;
  logic          req_valid, req_ready, req_write, req_ext;
  logic [AW-1:0] req_area;
  logic          dn_valid, dn_ready, dn_write, dn_ext, gap_stall;
  logic [AW-1:0] dn_area;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Bench model state
  logic [7:0]    m_cfg  = 8'hD0;
  bit            m_vld  = 0;
  bit            m_read = 0;
  logic [AW-1:0] m_area = '0;
  bit            m_done = 0;
  bit            last_hs;
  int            gaps_seen;

  always #2 clk = ~clk;

  bus_idle_gap #(.AREA_W(AW)) dut (
    .clk(clk), .por_n(por_n), .man_n(man_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .area0_burst(area0_burst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_area(req_area), .req_ext(req_ext),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
    .dn_area(dn_area), .dn_ext(dn_ext), .gap_stall(gap_stall)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_gap(logic [7:0] c, bit vld, bit rd, logic [AW-1:0] la,
                                 bit w, logic [AW-1:0] a, bit ext);
    if (!ext || !vld || !rd) return 0;
    if (w) return c[6];
    return c[7] && (a != la);
  endfunction

  function automatic string gap_tag(bit w, logic [AW-1:0] a, bit ext);
    if (!ext)               return "R7";
    if (!m_vld)             return "R8";
    if (!m_read)            return "R6";
    if (w)                  return "R5";
    if (a != m_area)        return "R4";
    return "R6";
  endfunction

  // Inputs are set at the falling edge; outputs checked 1 ns later.
  task automatic eval();
    bit run, es, ev, er;
    #1;
    run = por_n && man_n;
    es  = run && req_valid && !m_done &&
          exp_gap(m_cfg, m_vld, m_read, m_area, req_write, req_area, req_ext);
    ev  = run && req_valid && !es;
    er  = run && dn_ready && !es;
    chk(gap_tag(req_write, req_area, req_ext), gap_stall, es);
    chk("R10 dn_valid", dn_valid, ev);
    chk("R10 req_ready", req_ready, er);
    if (ev) begin
      chk("R10 dn_area", dn_area, req_area);
      chk("R10 dn_write", dn_write, req_write);
      chk("R10 dn_ext", dn_ext, req_ext);
    end
    chk("R3 readback", cfg_rdata, m_cfg);
    chk("R9 burst", area0_burst, m_cfg[5]);
    if (es) gaps_seen++;
    last_hs = ev && dn_ready;
    if (!por_n) begin
      m_cfg = 8'hD0; m_vld = 0; m_done = 0;
    end else begin
      if (cfg_we) m_cfg = cfg_wdata;
      if (!man_n) begin
        m_vld = 0; m_done = 0;
      end else if (last_hs) begin
        m_done = 0;
        if (req_ext) begin m_vld = 1; m_read = !req_write; m_area = req_area; end
      end else if (es) m_done = 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_wdata = '0; req_valid = 0; req_write = 0;
    req_area = '0; req_ext = 1; dn_ready = 1;
  endtask

  // Presents one request until it is accepted; returns idle states seen.
  task automatic xfer(bit w, int a, bit ext, int stall_rdy, output int gaps);
    int cyc = 0;
    gaps_seen = 0;
    req_valid = 1; req_write = w; req_area = AW'(a); req_ext = ext;
    do begin
      dn_ready = (cyc >= stall_rdy);
      eval();
      cyc++;
    end while (!last_hs);
    req_valid = 0; dn_ready = 1;
    gaps = gaps_seen;
  endtask

  task automatic cfg_write(logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    eval();
    cfg_we = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int g;
    void'($urandom(32'd20240611));
    idle_inputs();
    por_n = 0; man_n = 1;
    @(negedge clk);
    eval(); eval(); eval();
    por_n = 1;
    #1;
    chk("R1 por value", cfg_rdata, 8'hD0);
    chk("R1 burst clear", area0_burst, 0);
    #0;
    @(negedge clk);

    // R8: first external access free; R4 change of area
    xfer(0, 1, 1, 0, g); chk("R8 first read gaps", g, 0);
    xfer(0, 2, 1, 0, g); chk("R4 rd-rd diff area", g, 1);
    xfer(0, 2, 1, 0, g); chk("R6 rd-rd same area", g, 0);
    xfer(1, 2, 1, 0, g); chk("R5 rd-wr", g, 1);
    xfer(0, 5, 1, 0, g); chk("R6 wr-rd", g, 0);
    xfer(1, 5, 1, 0, g); chk("R5 rd-wr same area", g, 1);
    xfer(1, 3, 1, 0, g); chk("R6 wr-wr", g, 0);
    // R7: internal access does not update record
    xfer(0, 1, 1, 0, g);
    xfer(0, 6, 0, 0, g); chk("R7 internal gaps", g, 0);
    xfer(0, 3, 1, 0, g); chk("R7 record kept", g, 1);
    // R10: back-pressure after the idle state
    xfer(0, 4, 1, 3, g); chk("R10 single gap under backpressure", g, 1);

    // R3/R4/R5: rules disabled
    cfg_write(8'h1F);
    chk("R3 write value", cfg_rdata, 8'h1F);
    xfer(0, 0, 1, 0, g); chk("R4 disabled", g, 0);
    xfer(1, 0, 1, 0, g); chk("R5 disabled", g, 0);
    // R11: write in same cycle as request uses old value
    xfer(0, 1, 1, 0, g);
    cfg_we = 1; cfg_wdata = 8'hC0;
    xfer(0, 2, 1, 0, g); chk("R11 same-cycle old value", g, 0);
    cfg_we = 0;
    xfer(0, 3, 1, 0, g); chk("R11 next request new value", g, 1);

    // R2: manual reset keeps register, clears record
    cfg_write(8'hE5);
    chk("R9 burst set", area0_burst, 1);
    xfer(0, 1, 1, 0, g);
    man_n = 0; eval(); eval(); man_n = 1;
    #1; chk("R2 register kept", cfg_rdata, 8'hE5);
    @(negedge clk);
    xfer(0, 4, 1, 0, g); chk("R2 record cleared, first free", g, 0);
    // R2: no acceptance during manual reset
    man_n = 0; req_valid = 1; req_ext = 1; dn_ready = 1;
    #1; chk("R2 ready low in reset", req_ready, 0); chk("R2 valid low in reset", dn_valid, 0);
    @(negedge clk); req_valid = 0; eval(); man_n = 1;

    // Random traffic
    begin
      bit pend = 0;
      for (int i = 0; i < 4000; i++) begin
        if (!pend && ($urandom % 4 != 0)) begin
          pend = 1;
          req_write = $urandom % 2; req_area = AW'($urandom % 8);
          req_ext = ($urandom % 6 != 0);
        end
        req_valid = pend;
        dn_ready  = ($urandom % 4 != 0);
        cfg_we    = ($urandom % 60 == 0);
        cfg_wdata = 8'($urandom);
        man_n     = ($urandom % 250 != 0);
        eval();
        if (last_hs) pend = 0;
      end
      idle_inputs(); man_n = 1;
    end

    // R1: power-on reset again restores default
    por_n = 0; eval(); por_n = 1;
    #1; chk("R1 por again", cfg_rdata, 8'hD0);
    @(negedge clk);
    xfer(1, 2, 1, 0, g); chk("R8 first after por", g, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule